// File: doc/BRIEF.md
# Supply-Fail Write-Protect Controller

This block decides, every clock, whether a battery-backed memory may be accessed. An external converter supplies a stream of supply-voltage samples, each an unsigned code in millivolts. A four-state sequencer compares each sample against three thresholds and drives four control lines: a write block, a gate that makes the memory ignore its access inputs, a force that puts the data outputs into high impedance, and a selector that chooses between the external supply and the backup cell.

After a factory reset the backup cell stays disconnected until the supply has once been seen above the operating level. From that point on, a falling supply is handled in two steps. First, access is frozen at the protect threshold. Second, the memory is moved onto the backup cell at the switch threshold. On the way back up, the memory returns to the external supply at the switch threshold, but normal access is restored only above the operating threshold. A sample that jumps across several thresholds at once still moves the sequencer only one state per sample. If the supply falls below the switch level while the seal is still intact, a sticky flag reports that memory contents were lost.

Samples arrive on a valid/ready interface. `smp_ready` is held high, so the block never applies back-pressure. A sample is consumed on every clock edge where `smp_valid` is high, and when `smp_valid` is low the block holds its state. All control outputs are decoded from the registered state, so each one changes in the clock that follows the edge consuming the sample.

Top module: `supply_guard`

## Requirements
- R1: While `rst_n` is low, `state_code` reads 0 (sealed), `wr_block`, `in_gate` and `out_hiz` are 1, and `src_batt`, `batt_armed` and `data_lost` are 0.
- R2: A clock edge with `smp_valid` low leaves the state and every output unchanged, whatever `smp_mv` holds. `smp_ready` is always 1.
- R3: In the sealed state (code 0), a sample above RUN_MV+HYST_MV (default above 3020) moves the block to normal (code 1) and sets `batt_armed`. `batt_armed` then stays 1 until reset.
- R4: In normal, `wr_block`, `in_gate`, `out_hiz` and `src_batt` are all 0. In the sealed and protected (code 2) states, the first three are 1 and `src_batt` is 0.
- R5: In normal, a sample at or below PROT_MV (default 2800) moves the block to protected, even when the sample is also below the switch level. Normal never goes straight to on-battery.
- R6: In protected, a sample below SW_MV-HYST_MV (default below 2480) moves the block to on-battery (code 3). In on-battery, `src_batt` is 1 and the three access controls stay 1.
- R7: In on-battery, a sample above SW_MV+HYST_MV (default above 2520) moves the block to protected, even when the sample is above the run level. On-battery never goes straight to normal.
- R8: In protected, a sample above RUN_MV+HYST_MV moves the block to normal. Samples inside the hysteresis bands (normal between 2801 and any level above, protected between 2480 and 3020, on-battery at or below 2520) leave the state unchanged.
- R9: In the sealed state, a sample below SW_MV (default below 2500) leaves `src_batt` at 0 and sets `data_lost`. `data_lost` stays 1 until reset.
- R10: `state_code` reports the encoding sealed=0, normal=1, protected=2, on-battery=3.
- R11: Once the block leaves the sealed state, it never returns to it without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; represents the factory state |
| smp_valid | input | 1 | Supply sample on `smp_mv` is valid this cycle |
| smp_ready | output | 1 | Always 1; no back-pressure |
| smp_mv | input | MV_W (13) | Supply voltage sample in millivolts, unsigned |
| wr_block | output | 1 | 1 blocks memory writes |
| in_gate | output | 1 | 1 makes the memory ignore its access inputs |
| out_hiz | output | 1 | 1 forces the memory data outputs to high impedance |
| src_batt | output | 1 | 1 powers the memory from the backup cell, 0 from the external supply |
| batt_armed | output | 1 | Seal broken; backup cell usable |
| data_lost | output | 1 | Sticky: supply dropped below switch level while sealed |
| state_code | output | 2 | Sequencer state, encoded as in R10 |

## Verification
The bench sends a single sample that lands far below both lower thresholds while the block is in normal. A design that compared against every threshold at once would then jump to on-battery and connect the backup cell while the memory was still writable. The bench also sends a sample above the run level while the block is on-battery. A design that resumed access at that point would re-enable writes while the supply source was still changing over. Other samples sit exactly on each threshold and one millivolt beyond it, which catches a comparator using the wrong relation or missing the hysteresis offset. Another group of samples falls well below the switch level while the block is sealed, and each of these must leave the backup cell disconnected and raise the lost flag. Finally, garbage values presented with `smp_valid` low must move nothing.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  typedef enum logic [1:0] {
    SG_SEALED = 2'd0,
    SG_NORMAL = 2'd1,
    SG_PROT   = 2'd2,
    SG_BATT   = 2'd3
  } sg_state_e;

  typedef struct packed {
    logic run_up;     // above operating level plus hysteresis
    logic prot_dn;    // at or below protect level
    logic batt_dn;    // below switch level minus hysteresis
    logic batt_up;    // above switch level plus hysteresis
    logic seal_low;   // below switch level, no hysteresis
  } sg_levels_t;

endpackage

// File: rtl/sg_thresh.sv
module sg_thresh
  import supply_guard_pkg::*;
#(
  parameter int MV_W    = 13,
  parameter int RUN_MV  = 3000,
  parameter int PROT_MV = 2800,
  parameter int SW_MV   = 2500,
  parameter int HYST_MV = 20
) (
  input  logic [MV_W-1:0] smp_mv,
  output sg_levels_t      lvl
);

  localparam logic [MV_W-1:0] RUN_UP  = MV_W'(RUN_MV + HYST_MV);
  localparam logic [MV_W-1:0] PROT_LV = MV_W'(PROT_MV);
  localparam logic [MV_W-1:0] SW_LV   = MV_W'(SW_MV);
  localparam logic [MV_W-1:0] SW_UP   = MV_W'(SW_MV + HYST_MV);

  generate
    if (HYST_MV > SW_MV) begin : g_floor
      // Hysteresis wider than the switch level: lower edge clamps at zero.
      assign lvl.batt_dn = 1'b0;
    end else begin : g_band
      localparam logic [MV_W-1:0] SW_DN = MV_W'(SW_MV - HYST_MV);
      assign lvl.batt_dn = (smp_mv < SW_DN);
    end
  endgenerate

  assign lvl.run_up   = (smp_mv > RUN_UP);
  assign lvl.prot_dn  = (smp_mv <= PROT_LV);
  assign lvl.batt_up  = (smp_mv > SW_UP);
  assign lvl.seal_low = (smp_mv < SW_LV);

endmodule

// File: rtl/sg_fsm.sv
module sg_fsm
  import supply_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_valid,
  input  sg_levels_t lvl,
  output sg_state_e  state_q,
  output logic       armed_q,
  output logic       lost_q
);

  sg_state_e state_d;
  logic      armed_d;
  logic      lost_d;

  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    lost_d  = lost_q;
    if (smp_valid) begin
      unique case (state_q)
        SG_SEALED: begin
          if (lvl.run_up) begin
            state_d = SG_NORMAL;
            armed_d = 1'b1;
          end else if (lvl.seal_low) begin
            lost_d = 1'b1;
          end
        end
        SG_NORMAL: begin
          if (lvl.prot_dn) state_d = SG_PROT;
        end
        SG_PROT: begin
          if (lvl.run_up)       state_d = SG_NORMAL;
          else if (lvl.batt_dn) state_d = SG_BATT;
        end
        SG_BATT: begin
          if (lvl.batt_up) state_d = SG_PROT;
        end
        default: state_d = SG_SEALED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SG_SEALED;
      armed_q <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      lost_q  <= lost_d;
    end
  end

  // R5
  normal_not_to_batt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SG_NORMAL) |=> (state_q != SG_BATT));

  // R7
  batt_not_to_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SG_BATT) |=> (state_q != SG_NORMAL));

  // R11
  no_reseal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SG_SEALED) |=> (state_q != SG_SEALED));

  // R9
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_q |=> lost_q);

  // R3
  armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(state_q) && $stable(lost_q) && $stable(armed_q)));

endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int MV_W    = 13,
  parameter int RUN_MV  = 3000,
  parameter int PROT_MV = 2800,
  parameter int SW_MV   = 2500,
  parameter int HYST_MV = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  output logic            smp_ready,
  input  logic [MV_W-1:0] smp_mv,
  output logic            wr_block,
  output logic            in_gate,
  output logic            out_hiz,
  output logic            src_batt,
  output logic            batt_armed,
  output logic            data_lost,
  output logic [1:0]      state_code
);

  sg_levels_t lvl;
  sg_state_e  state_q;
  logic       armed_q;
  logic       lost_q;
  logic       locked;

  sg_thresh #(
    .MV_W(MV_W), .RUN_MV(RUN_MV), .PROT_MV(PROT_MV),
    .SW_MV(SW_MV), .HYST_MV(HYST_MV)
  ) u_thresh (
    .smp_mv(smp_mv),
    .lvl   (lvl)
  );

  sg_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .lvl      (lvl),
    .state_q  (state_q),
    .armed_q  (armed_q),
    .lost_q   (lost_q)
  );

  assign locked     = (state_q != SG_NORMAL);
  assign smp_ready  = 1'b1;
  assign wr_block   = locked;
  assign in_gate    = locked;
  assign out_hiz    = locked;
  assign src_batt   = (state_q == SG_BATT);
  assign batt_armed = armed_q;
  assign data_lost  = lost_q;
  assign state_code = state_q;

  // R9
  seal_keeps_cell_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !batt_armed |-> !src_batt);

  // R6
  batt_fully_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_batt |-> (wr_block && in_gate && out_hiz));

  // R3
  armed_matches_unsealed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    batt_armed |-> (state_code != 2'd0));

endmodule

// File: tb/supply_guard_bench.sv
`timescale 1ns/1ps
module supply_guard_bench;

  localparam int MV_W = 13;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            smp_valid = 1'b0;
  logic            smp_ready;
  logic [MV_W-1:0] smp_mv = '0;
  logic            wr_block, in_gate, out_hiz, src_batt;
  logic            batt_armed, data_lost;
  logic [1:0]      state_code;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [1:0] q_st[$];
  logic       q_lost[$];
  logic       q_arm[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  supply_guard u_supply_guard (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_mv(smp_mv), .wr_block(wr_block), .in_gate(in_gate), .out_hiz(out_hiz),
    .src_batt(src_batt), .batt_armed(batt_armed), .data_lost(data_lost),
    .state_code(state_code)
  );

  // R4 / R6: control lines expected for each state code {wr,gate,hiz,src}
  function automatic logic [3:0] ctl_for(input logic [1:0] st);
    case (st)
      2'd1:    return 4'b0000;
      2'd3:    return 4'b1111;
      default: return 4'b1110;
    endcase
  endfunction

  task automatic compare(input logic [1:0] st, input logic lost, input logic arm,
                         input string tag);
    logic [3:0] exp_ctl;
    logic [3:0] got_ctl;
    exp_ctl = ctl_for(st);
    got_ctl = {wr_block, in_gate, out_hiz, src_batt};
    n_vec++;
    if (state_code !== st || got_ctl !== exp_ctl || data_lost !== lost ||
        batt_armed !== arm || smp_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: got st=%0d ctl=%b lost=%b arm=%b rdy=%b, expected st=%0d ctl=%b lost=%b arm=%b rdy=1",
               tag, state_code, got_ctl, data_lost, batt_armed, smp_ready,
               st, exp_ctl, lost, arm);
    end
  endtask

  // Driver: applies one sample and pushes the expected result.
  task automatic apply(input int mv, input logic v, input logic [1:0] st,
                       input logic lost, input logic arm, input string tag);
    @(negedge clk);
    smp_mv    = MV_W'(mv);
    smp_valid = v;
    q_st.push_back(st);
    q_lost.push_back(lost);
    q_arm.push_back(arm);
    q_tag.push_back(tag);
  endtask

  // Monitor: one item consumed per edge, checked just after it.
  always @(posedge clk) begin
    #1;
    if (q_st.size() > 0) begin
      logic [1:0] st;
      logic       lo;
      logic       ar;
      string      tg;
      st = q_st.pop_front();
      lo = q_lost.pop_front();
      ar = q_arm.pop_front();
      tg = q_tag.pop_front();
      compare(st, lo, ar, tg);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(2'd0, 1'b0, 1'b0, "R1 reset state");
    rst_n = 1'b1;

    apply(0,    1, 2'd0, 1, 0, "R9 sealed drop sets lost, cell off");
    apply(1000, 1, 2'd0, 1, 0, "R9 lost sticky while sealed");
    apply(3020, 1, 2'd0, 1, 0, "R3 at run+hyst stays sealed");
    apply(3500, 0, 2'd0, 1, 0, "R2 invalid sample ignored");
    apply(3021, 1, 2'd1, 1, 1, "R3 unseal to normal, R10 code 1");
    apply(2801, 1, 2'd1, 1, 1, "R4 normal just above protect level");
    apply(2800, 1, 2'd2, 1, 1, "R5 protect at threshold, R10 code 2");
    apply(3010, 1, 2'd2, 1, 1, "R8 protected hysteresis band holds");
    apply(3100, 1, 2'd1, 1, 1, "R8 resume normal");
    apply(100,  1, 2'd2, 1, 1, "R5 deep drop passes through protected");
    apply(2480, 1, 2'd2, 1, 1, "R8 switch band holds protected");
    apply(100,  0, 2'd2, 1, 1, "R2 invalid low sample ignored");
    apply(2479, 1, 2'd3, 1, 1, "R6 onto backup cell, R10 code 3");
    apply(2520, 1, 2'd3, 1, 1, "R7 on-battery band holds");
    apply(3300, 1, 2'd2, 1, 1, "R7 high sample returns only to protected");
    apply(3300, 1, 2'd1, 1, 1, "R8 next high sample resumes normal");
    apply(0,    1, 2'd2, 1, 1, "R5 second fall protects first");
    apply(0,    1, 2'd3, 1, 1, "R6 then backup cell");
    apply(0,    1, 2'd3, 1, 1, "R11 stays on battery, no reseal");
    apply(2521, 1, 2'd2, 1, 1, "R7 back to external supply");
    apply(2000, 1, 2'd3, 1, 1, "R6 again to backup cell");

    @(negedge clk);
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    compare(2'd0, 1'b0, 1'b0, "R1 reset re-seals");
    rst_n = 1'b1;
    apply(2600, 1, 2'd0, 0, 0, "R9 sealed above switch level, lost clear");
    apply(4000, 1, 2'd1, 0, 1, "R3 unseal without loss");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule